// File: doc/BRIEF.md
# Multi-Link Power and Bank-Switch Sync Controller

This block is a small register-mapped controller placed in front of up to four serial audio bus link controllers. Software uses it for two jobs. The first is to power links up and down. A request bit per link drives a power-enable output. A matching ready status reads back only after the request has been stable for a fixed settle time and the link reports power-good.

The second job is to make several links change register bank in the same clock cycle. A free-running down-counter produces a one-cycle frame sync tick at a programmable period. Software first arms the links that take part. It then writes a single "go" bit. At the next sync tick, every armed link receives a one-cycle bank-switch strobe in the same cycle, and all arm flags clear together. A period change is staged by software and takes effect at a sync tick, so the tick spacing never shows a partial count.

Access uses a single-cycle 32-bit write port with a combinational read port. The link-control register sits at offset 0x4 and the sync-control register at offset 0xC.

Top module: `lnk_sync_shim`

## Requirements
- R1: After reset, offset 0x4 reads 0x0000_0000 and offset 0xC reads 0x0000_176F. `link_pwr_req` and `bank_sw` are zero.
- R2: In the link-control register, bit n is link n's power request. It reads back as written and drives `link_pwr_req[n]`.
- R3: Bit 8+n of the link-control register reads 1 only while `link_pwr_ok[n]` is high and link n's settled power state is on.
  - The settled state turns on 4 cycles after the write edge that set the request.
  - It turns off 4 cycles after the write edge that cleared the request.
- R4: A request that is reverted within the settle time never changes the settled state.
- R5: `sync_pulse` is high for one cycle every P+1 cycles, where P is the committed 15-bit period. The period after reset is 0x176F.
- R6: In the sync-control register, bits 14:0 hold the staged period and read back as written.
  - Writing 1 to bit 15 requests a commit. Bit 15 then reads 1 until the next sync tick.
  - At that tick the staged period is adopted, and it governs the tick spacing from then on.
- R7: Writing 1 to bit 16+n of the sync-control register arms link n. Writing 0 to an arm bit leaves it unchanged.
  - Arm bits set in the same write as the go bit take part in that switch.
- R8: Writing 1 to bit 24 while at least one link is armed makes bit 24 read 1 until the next sync tick.
  - In that tick's cycle, `bank_sw[n]` is high for exactly one cycle on every armed link.
  - After that cycle, bit 24 and all arm bits read 0.
- R9: Writing 1 to bit 24 while no link is armed has no effect. Bit 24 reads 0 and no `bank_sw` strobe occurs.
- R10: Reserved bits read 0 and ignore writes. Offsets other than 0x4 and 0xC read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| link_pwr_ok | input | 4 | Per-link power-good indication |
| link_pwr_req | output | 4 | Per-link power enable |
| sync_pulse | output | 1 | One-cycle frame sync tick |
| bank_sw | output | 4 | Per-link bank-switch strobe |

## Verification
Most of the state in this block is visible through the register port within one cycle of a fault. A go flag or arm flag that sticks shows as bits 24 or 19:16 still set right after the tick that should have cleared them. It also shows as a strobe at a later tick. A miscounted settle counter moves the ready bit by whole cycles, so the bench samples that bit at both the third and the fourth cycle after the write. A wrong commit point in the period logic shows in the measured tick spacing and in how long the commit bit stays set. A stray strobe is compared against an expected-strobe queue on every cycle it appears.

// File: rtl/lnk_sync_pkg.sv
package lnk_sync_pkg;
  localparam int REG_DW      = 32;
  localparam int OFS_LINKCTL = 'h04;
  localparam int OFS_SYNCCTL = 'h0C;
  localparam int RDY_LSB     = 8;
  localparam int LD_BIT      = 15;
  localparam int ARM_LSB     = 16;
  localparam int GO_BIT      = 24;
endpackage

// File: rtl/lnk_pwr_seq.sv
// Per-link power settle sequencer: the settled state follows the request
// only after the request has differed from it for DLY cycles in a row.
module lnk_pwr_seq #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rdy
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  always_comb begin
    cnt_d = '0;
    rdy_d = rdy_q;
    if (req != rdy_q) begin
      if (cnt_q == CW'(DLY - 1)) begin
        rdy_d = req;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign rdy = rdy_q;
endmodule

// File: rtl/sync_tick_gen.sv
// Frame sync down-counter with a staged period committed at a tick.
module sync_tick_gen #(
  parameter int              PER_W   = 15,
  parameter logic [PER_W-1:0] PER_RST = 15'h176F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] stage_per,
  input  logic             ld_req,
  output logic             ld_pend,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             ld_q, ld_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q - 1'b1;
    if (at_zero) begin
      if (ld_q) begin
        per_d = stage_per;
        cnt_d = stage_per;
      end else begin
        cnt_d = per_q;
      end
    end
    ld_d = ld_req | (ld_q & ~at_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= PER_RST;
      per_q <= PER_RST;
      ld_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      ld_q  <= ld_d;
    end
  end

  assign tick    = at_zero;
  assign ld_pend = ld_q;
endmodule

// File: rtl/bank_sw_ctrl.sv
// Arm flags and the go flag; fires one aligned strobe on the next tick.
module bank_sw_ctrl #(
  parameter int N_LINKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [N_LINKS-1:0] arm_set,
  input  logic               go_wr,
  output logic [N_LINKS-1:0] arm,
  output logic               go_pend,
  output logic [N_LINKS-1:0] bank_sw
);
  logic [N_LINKS-1:0] arm_q, arm_d;
  logic               go_q, go_d;
  logic               fire;

  assign fire = go_q & tick;

  always_comb begin
    arm_d = (fire ? '0 : arm_q) | arm_set;
    go_d  = ((go_q & ~fire) | go_wr) & (|arm_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      go_q  <= 1'b0;
    end else begin
      arm_q <= arm_d;
      go_q  <= go_d;
    end
  end

  assign bank_sw = arm_q & {N_LINKS{fire}};
  assign arm     = arm_q;
  assign go_pend = go_q;
endmodule

// File: rtl/lnk_sync_shim.sv
module lnk_sync_shim
  import lnk_sync_pkg::*;
#(
  parameter int              N_LINKS = 4,
  parameter int              ADDR_W  = 8,
  parameter int              PWR_DLY = 4,
  parameter int              PER_W   = 15,
  parameter logic [PER_W-1:0] PER_RST = 15'h176F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic [N_LINKS-1:0] link_pwr_ok,
  output logic [N_LINKS-1:0] link_pwr_req,
  output logic               sync_pulse,
  output logic [N_LINKS-1:0] bank_sw
);
  localparam logic [ADDR_W-1:0] A_LCTL = ADDR_W'(OFS_LINKCTL);
  localparam logic [ADDR_W-1:0] A_SYNC = ADDR_W'(OFS_SYNCCTL);

  // reset: asserted asynchronously, released after two clock edges
  logic rst_m, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  logic wr_lctl, wr_sync;
  assign wr_lctl = reg_we && (reg_addr == A_LCTL);
  assign wr_sync = reg_we && (reg_addr == A_SYNC);

  logic [N_LINKS-1:0] req_q, req_d;
  logic [PER_W-1:0]   stage_q, stage_d;

  always_comb begin
    req_d   = req_q;
    stage_d = stage_q;
    if (wr_lctl) req_d   = reg_wdata[N_LINKS-1:0];
    if (wr_sync) stage_d = reg_wdata[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      req_q   <= '0;
      stage_q <= PER_RST;
    end else begin
      req_q   <= req_d;
      stage_q <= stage_d;
    end
  end

  logic [N_LINKS-1:0] rdy;
  for (genvar i = 0; i < N_LINKS; i++) begin : g_pwr
    lnk_pwr_seq #(.DLY(PWR_DLY)) u_seq (
      .clk  (clk),
      .rst_n(rst_sn),
      .req  (req_q[i]),
      .rdy  (rdy[i])
    );
  end

  logic ld_pend, tick;
  sync_tick_gen #(.PER_W(PER_W), .PER_RST(PER_RST)) u_tick (
    .clk      (clk),
    .rst_n    (rst_sn),
    .stage_per(stage_q),
    .ld_req   (wr_sync & reg_wdata[LD_BIT]),
    .ld_pend  (ld_pend),
    .tick     (tick)
  );

  logic [N_LINKS-1:0] arm_set, arm;
  logic               go_pend;
  assign arm_set = wr_sync ? reg_wdata[ARM_LSB +: N_LINKS] : '0;

  bank_sw_ctrl #(.N_LINKS(N_LINKS)) u_bsw (
    .clk    (clk),
    .rst_n  (rst_sn),
    .tick   (tick),
    .arm_set(arm_set),
    .go_wr  (wr_sync & reg_wdata[GO_BIT]),
    .arm    (arm),
    .go_pend(go_pend),
    .bank_sw(bank_sw)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_LCTL) begin
      reg_rdata[N_LINKS-1:0]         = req_q;
      reg_rdata[RDY_LSB +: N_LINKS]  = rdy & link_pwr_ok;
    end else if (reg_addr == A_SYNC) begin
      reg_rdata[PER_W-1:0]           = stage_q;
      reg_rdata[LD_BIT]              = ld_pend;
      reg_rdata[ARM_LSB +: N_LINKS]  = arm;
      reg_rdata[GO_BIT]              = go_pend;
    end
  end

  assign link_pwr_req = req_q;
  assign sync_pulse   = tick;
endmodule

module lnk_sync_shim_chk #(
  parameter int N_LINKS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_pulse,
  input logic [N_LINKS-1:0] bank_sw,
  input logic [N_LINKS-1:0] arm,
  input logic               go_pend,
  input logic               ld_pend,
  input logic [N_LINKS-1:0] req,
  input logic [N_LINKS-1:0] rdy
);
  // R8
  bsw_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_sw) |-> sync_pulse);

  // R9
  go_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pend |-> (|arm));

  // R3
  rdy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy & ~$past(rdy) & ~$past(req)) == '0);

  // R6
  ld_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_pend) |-> $past(sync_pulse));

  // R4
  rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~rdy & $past(rdy) & $past(req)) == '0);
endmodule

bind lnk_sync_shim lnk_sync_shim_chk #(.N_LINKS(N_LINKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .sync_pulse(sync_pulse),
  .bank_sw   (bank_sw),
  .arm       (arm),
  .go_pend   (go_pend),
  .ld_pend   (ld_pend),
  .req       (req_q),
  .rdy       (rdy)
);

// File: tb/lnk_sync_shim_test.sv
module lnk_sync_shim_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  link_pwr_ok;
  logic [3:0]  link_pwr_req;
  logic        sync_pulse;
  logic [3:0]  bank_sw;

  localparam logic [7:0] LCTL = 8'h04;
  localparam logic [7:0] SYNC = 8'h0C;

  int n_cmp = 0;
  int n_bad = 0;
  int n_unexp = 0;
  logic [3:0] exp_q[$];
  logic [3:0] prev_bsw = '0;

  always #4 clk = ~clk;

  lnk_sync_shim uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_pwr_ok(link_pwr_ok),
    .link_pwr_req(link_pwr_req), .sync_pulse(sync_pulse), .bank_sw(bank_sw)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spacing(input string tag, input int exp);
    int k = 0;
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!sync_pulse && guard < 10000);
    do begin @(negedge clk); k++; end while (!sync_pulse && k < 10000);
    chk(tag, k, exp);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: every strobe must match the next expected mask
  always @(negedge clk) begin
    if (rst_n) begin
      if (bank_sw != '0) begin
        if (prev_bsw != '0) begin
          n_cmp++; n_bad++;
          $display("FAIL R8 strobe wider than one cycle: actual %b expected 0000", bank_sw);
        end
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++; n_unexp++;
          $display("FAIL R9 unexpected strobe: actual %b expected 0000", bank_sw);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          if (bank_sw !== e || !sync_pulse) begin
            n_bad++;
            $display("FAIL R8 strobe: actual %b/%b expected %b/1", bank_sw, sync_pulse, e);
          end
        end
      end
      prev_bsw <= bank_sw;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1-all: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    link_pwr_ok = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(3);

    // R1 reset state
    rd(LCTL, d); chk("R1 lctl", d, 32'h0);
    rd(SYNC, d); chk("R1 sync", d, 32'h0000_176F);
    chk("R1 outputs", {link_pwr_req, bank_sw}, 32'h0);

    // R2 / R3 power up of link 0
    wr(LCTL, 32'h1);
    chk("R2 req out", link_pwr_req, 32'h1);
    step(3); rd(LCTL, d); chk("R3 not yet ready", d, 32'h0000_0001);
    step(1); rd(LCTL, d); chk("R3 ready", d, 32'h0000_0101);
    wr(LCTL, 32'h0);
    step(3); rd(LCTL, d); chk("R3 still ready", d, 32'h0000_0100);
    step(1); rd(LCTL, d); chk("R3 dropped", d, 32'h0);

    // R4 short request pulse on link 1
    wr(LCTL, 32'h2);
    wr(LCTL, 32'h0);
    step(6); rd(LCTL, d); chk("R4 glitch ignored", d, 32'h0);

    // R3 power-good low masks ready
    link_pwr_ok = 4'b1011;
    wr(LCTL, 32'h4);
    step(6); rd(LCTL, d); chk("R3 ok low", d, 32'h0000_0004);
    link_pwr_ok = 4'hF;
    rd(LCTL, d); chk("R3 ok high", d, 32'h0000_0404);

    // R10 reserved bits and unmapped offsets
    wr(LCTL, 32'hFFFF_FFFF);
    step(6); rd(LCTL, d); chk("R10 lctl reserved", d, 32'h0000_0F0F);
    wr(LCTL, 32'h0);
    rd(8'h00, d); chk("R10 off 0", d, 32'h0);
    rd(8'h08, d); chk("R10 off 8", d, 32'h0);

    // R5 default period
    spacing("R5 default spacing", 32'h1770);

    // R6 commit a new period of 9
    wr(SYNC, 32'h0000_8009);
    rd(SYNC, d); chk("R6 load pending", d, 32'h0000_8009);
    begin
      int g = 0;
      do begin step(1); rd(SYNC, d); g++; end while (d[15] && g < 7000);
    end
    chk("R6 load done", d, 32'h0000_0009);
    spacing("R5 new spacing a", 10);
    spacing("R5 new spacing b", 10);

    // R7 arming, and writing 0 leaves arms
    wr(SYNC, 32'h0005_0009);
    rd(SYNC, d); chk("R7 armed", d, 32'h0005_0009);
    wr(SYNC, 32'h0000_0009);
    rd(SYNC, d); chk("R7 zero keeps", d, 32'h0005_0009);

    // R8 go with links 0 and 2 armed
    exp_q.push_back(4'b0101);
    wr(SYNC, 32'h0100_0009);
    rd(SYNC, d); chk("R8 go pending", d, 32'h0105_0009);
    step(12);
    rd(SYNC, d); chk("R8 cleared", d, 32'h0000_0009);
    chk("R8 strobe seen", exp_q.size(), 0);

    // R7/R8 arm and go in one write
    exp_q.push_back(4'b1010);
    wr(SYNC, 32'h010A_0009);
    step(12);
    rd(SYNC, d); chk("R8 combined cleared", d, 32'h0000_0009);
    chk("R8 combined strobe seen", exp_q.size(), 0);

    // R9 go with nothing armed
    wr(SYNC, 32'h0100_0009);
    rd(SYNC, d); chk("R9 go ignored", d, 32'h0000_0009);
    step(25);
    chk("R9 no strobe", n_unexp, 0);
    chk("R10 sync reserved", d & 32'hFEF0_0000, 32'h0);

    report();
    $finish;
  end
endmodule